// File: doc/BRIEF.md
# Memory-Mapped Terminal Device Registers

This peripheral lets a processor talk to a keyboard model and a display model through four 32-bit registers in a 16-byte window at the top of the address space. The processor uses plain loads and stores on a single-cycle slave port. Read data is combinational in the cycle of the access. Register side effects take place at the clock edge that closes the access.

The receive channel latches each byte that the keyboard presents with a one-cycle valid strobe and raises its ready flag. The flag clears when software loads the receive data register. The transmit channel takes the low byte of a store to its data register and hands it to the display with a one-cycle start pulse. Its ready flag stays low until the display pulses done. Each channel has a software-writable interrupt enable. Each channel drives its own interrupt line, which is high while both its ready flag and its enable are set. Software can therefore poll the ready flags or wait on the interrupt lines.

Top module: `mmio_term`

## Requirements
- R1: The window holds four word registers at BASE+0x0 (receive control), BASE+0x4 (receive data), BASE+0x8 (transmit control) and BASE+0xC (transmit data), with BASE = 0xFFFF0000 by default. An address outside the window reads as zero, and so does an address whose two low bits are not zero. A store to such an address changes nothing.
- R2: In both control registers, bit 0 is the ready flag and software cannot write it. Bit 1 is the interrupt enable, which a store sets to bit 1 of the stored word. Bits 31:2 always read as zero.
- R3: A keyboard valid strobe sets the receive ready flag and captures the byte. The receive data register returns that byte in bits 7:0, with bits 31:8 zero.
- R4: A load from the receive data register returns the current byte and clears receive ready at the end of that cycle. A load from the receive control register leaves the flag unchanged. If a key strobe arrives in the same cycle as the data load, the flag stays set and the new byte is captured.
- R5: A key strobe that arrives while receive ready is already 1 overwrites the held byte, and the flag stays 1.
- R6: A store to the transmit data register while transmit ready is 1 does three things one cycle later: it drives the stored low byte on the display byte output, pulses display start high for exactly one cycle, and clears transmit ready.
- R7: A store to the transmit data register while transmit ready is 0 is ignored. No start pulse follows and the display byte does not change.
- R8: A display done pulse while transmit ready is 0 sets transmit ready at the next clock edge.
- R9: Each interrupt line is high exactly when its channel's ready flag and interrupt enable are both 1.
- R10: Reset clears receive ready, both enables, the captured byte, the display byte and the start pulse, and sets transmit ready to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid in the access cycle |
| kbd_valid | input | 1 | One-cycle strobe: new key byte |
| kbd_byte | input | 8 | Key byte |
| disp_byte | output | 8 | Byte handed to the display |
| disp_start | output | 1 | One-cycle pulse: display byte is new |
| disp_done | input | 1 | Pulse: display finished the last byte |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
Each channel's state is a ready flag, an enable and one byte. A fault in any of them shows at the ports within one cycle: on the interrupt line right away, on the control read data at the next poll, or as a missing or extra start pulse one cycle after a store. A lost clear on the receive side shows as a stale ready flag at the next control read. A wrongly accepted store while the transmitter is busy shows as a changed display byte and a spurious start pulse. The tests therefore read the control registers after every event, and they cover the same-cycle collision of a key strobe with a data load.

// File: rtl/term_pkg.sv
package term_pkg;

  typedef enum logic [1:0] {
    REG_RXCTL = 2'd0,
    REG_RXDAT = 2'd1,
    REG_TXCTL = 2'd2,
    REG_TXDAT = 2'd3
  } term_reg_e;

  localparam int NUM_REGS = 4;
  localparam int RDY_BIT  = 0;
  localparam int IE_BIT   = 1;

  // Control word: ready in bit 0, enable in bit 1, rest zero.
  function automatic logic [31:0] ctl_word(input logic rdy, input logic ie);
    logic [31:0] w;
    w = '0;
    w[RDY_BIT] = rdy;
    w[IE_BIT]  = ie;
    return w;
  endfunction

  // Byte placed in the low lane of a zeroed word.
  function automatic logic [31:0] byte_word(input logic [7:0] b);
    return {24'd0, b};
  endfunction

endpackage

// File: rtl/term_bus_dec.sv
module term_bus_dec
  import term_pkg::*;
#(
  parameter int          AW   = 32,
  parameter logic [31:0] BASE = 32'hFFFF_0000
) (
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  output logic                hit,
  output term_reg_e           idx,
  output logic [NUM_REGS-1:0] rd_stb,
  output logic [NUM_REGS-1:0] wr_stb
);
  localparam logic [AW-1:0] BASE_A = BASE[AW-1:0];

  logic in_win;
  assign in_win = (bus_addr[AW-1:4] == BASE_A[AW-1:4]) && (bus_addr[1:0] == 2'b00);
  assign hit    = bus_sel && in_win;
  assign idx    = term_reg_e'(bus_addr[3:2]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
    assign rd_stb[g] = hit && !bus_we && (bus_addr[3:2] == 2'(g));
    assign wr_stb[g] = hit &&  bus_we && (bus_addr[3:2] == 2'(g));
  end
endmodule

// File: rtl/term_rx_chan.sv
module term_rx_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kbd_valid,
  input  logic [DW-1:0] kbd_byte,
  input  logic          data_rd,
  input  logic          ctl_wr,
  input  logic          ie_in,
  output logic          rdy,
  output logic          ie,
  output logic [DW-1:0] data,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      ie   <= 1'b0;
      data <= '0;
    end else begin
      if (kbd_valid) begin
        rdy  <= 1'b1;
        data <= kbd_byte;
      end else if (data_rd) begin
        rdy  <= 1'b0;
      end
      if (ctl_wr) ie <= ie_in;
    end
  end

  assign irq = rdy & ie;
endmodule

// File: rtl/term_tx_chan.sv
module term_tx_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_wr,
  input  logic [DW-1:0] wbyte,
  input  logic          ctl_wr,
  input  logic          ie_in,
  input  logic          done,
  output logic          rdy,
  output logic          ie,
  output logic          accept,
  output logic [DW-1:0] out_byte,
  output logic          start,
  output logic          irq
);
  assign accept = data_wr & rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy      <= 1'b1;
      ie       <= 1'b0;
      out_byte <= '0;
      start    <= 1'b0;
    end else begin
      start <= accept;
      if (accept) begin
        out_byte <= wbyte;
        rdy      <= 1'b0;
      end else if (done) begin
        rdy      <= 1'b1;
      end
      if (ctl_wr) ie <= ie_in;
    end
  end

  assign irq = rdy & ie;
endmodule

// File: rtl/mmio_term.sv
module mmio_term
  import term_pkg::*;
#(
  parameter logic [31:0] BASE = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        kbd_valid,
  input  logic [7:0]  kbd_byte,
  output logic [7:0]  disp_byte,
  output logic        disp_start,
  input  logic        disp_done,
  output logic        irq_rx,
  output logic        irq_tx
);
  localparam int DW = 8;

  logic                hit;
  term_reg_e           idx;
  logic [NUM_REGS-1:0] rd_stb, wr_stb;
  logic                rx_rdy, rx_ie, tx_rdy, tx_ie, tx_accept;
  logic [DW-1:0]       rx_data;
  logic                rx_rd_stb, tx_store;
  logic [31:0]         mux_word;
  logic                unused_wdata_bits;

  assign unused_wdata_bits = ^bus_wdata[31:DW];

  term_bus_dec #(.AW(32), .BASE(BASE)) u_dec (
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .hit(hit), .idx(idx), .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  assign rx_rd_stb = rd_stb[REG_RXDAT];
  assign tx_store  = wr_stb[REG_TXDAT];

  term_rx_chan #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
    .data_rd(rx_rd_stb), .ctl_wr(wr_stb[REG_RXCTL]), .ie_in(bus_wdata[IE_BIT]),
    .rdy(rx_rdy), .ie(rx_ie), .data(rx_data), .irq(irq_rx)
  );

  term_tx_chan #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .data_wr(tx_store), .wbyte(bus_wdata[DW-1:0]),
    .ctl_wr(wr_stb[REG_TXCTL]), .ie_in(bus_wdata[IE_BIT]), .done(disp_done),
    .rdy(tx_rdy), .ie(tx_ie), .accept(tx_accept),
    .out_byte(disp_byte), .start(disp_start), .irq(irq_tx)
  );

  always_comb begin
    case (idx)
      REG_RXCTL: mux_word = ctl_word(rx_rdy, rx_ie);
      REG_RXDAT: mux_word = byte_word(rx_data);
      REG_TXCTL: mux_word = ctl_word(tx_rdy, tx_ie);
      default:   mux_word = 32'd0;
    endcase
  end

  assign bus_rdata = (hit && !bus_we) ? mux_word : 32'd0;
endmodule

// File: rtl/term_chk.sv
module term_chk
  import term_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        hit,
  input term_reg_e   idx,
  input logic        kbd_valid,
  input logic [7:0]  kbd_byte,
  input logic        rx_rdy,
  input logic        rx_ie,
  input logic [7:0]  rx_data,
  input logic        rx_rd_stb,
  input logic        tx_rdy,
  input logic        tx_accept,
  input logic        tx_store,
  input logic [7:0]  disp_byte,
  input logic        disp_start,
  input logic        disp_done,
  input logic        irq_rx,
  input logic        irq_tx
);
  assert_miss_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !hit) |-> (bus_rdata == 32'd0));

  assert_ctl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !bus_we && (idx == REG_RXCTL || idx == REG_TXCTL)) |-> (bus_rdata[31:2] == 30'd0));

  assert_key_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid |=> (rx_rdy && rx_data == $past(kbd_byte)));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_stb && !kbd_valid) |=> !rx_rdy);

  assert_store_sends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> (!tx_rdy && disp_start && disp_byte == $past(bus_wdata[7:0])));

  assert_busy_store_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_store && !tx_rdy) |=> ($stable(disp_byte) && !disp_start));

  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_done && !tx_rdy) |=> tx_rdy);

  assert_irq_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (rx_rdy && rx_ie));

  assert_irq_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> tx_rdy);
endmodule

bind mmio_term term_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit(hit), .idx(idx),
  .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
  .rx_rdy(rx_rdy), .rx_ie(rx_ie), .rx_data(rx_data), .rx_rd_stb(rx_rd_stb),
  .tx_rdy(tx_rdy), .tx_accept(tx_accept), .tx_store(tx_store),
  .disp_byte(disp_byte), .disp_start(disp_start), .disp_done(disp_done),
  .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/test_mmio_term.sv
`timescale 1ns/1ps
module test_mmio_term;
  localparam logic [31:0] B = 32'hFFFF_0000;
  localparam logic [31:0] A_RXC = B + 32'h0, A_RXD = B + 32'h4;
  localparam logic [31:0] A_TXC = B + 32'h8, A_TXD = B + 32'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        kbd_valid = 1'b0;
  logic [7:0]  kbd_byte = '0;
  logic [7:0]  disp_byte;
  logic        disp_start;
  logic        disp_done = 1'b0;
  logic        irq_rx, irq_tx;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mmio_term i_mmio_term (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid), .kbd_byte(kbd_byte),
    .disp_byte(disp_byte), .disp_start(disp_start), .disp_done(disp_done),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic key(input logic [7:0] b);
    @(negedge clk);
    kbd_valid = 1'b1; kbd_byte = b;
    @(negedge clk);
    kbd_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    disp_done = 1'b1;
    @(negedge clk);
    disp_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 irq_rx", 32'(irq_rx), 0);
    chk("R10 irq_tx", 32'(irq_tx), 0);
    chk("R10 disp_start", 32'(disp_start), 0);
    chk("R10 disp_byte", 32'(disp_byte), 0);
    rd(A_RXC, d); chk("R10 rx ctl", d, 32'h0);
    rd(A_TXC, d); chk("R10 tx ctl", d, 32'h1);
    rd(A_RXD, d); chk("R10 rx data", d, 32'h0);
  endtask

  task automatic t_rx_basic();
    logic [31:0] d;
    key(8'h41);
    rd(A_RXC, d); chk("R3 ready after key", d, 32'h1);
    rd(A_RXC, d); chk("R4 ctl read keeps ready", d, 32'h1);
    rd(A_RXD, d); chk("R3 data zero-extended", d, 32'h41);
    rd(A_RXC, d); chk("R4 data read clears ready", d, 32'h0);
  endtask

  task automatic t_rx_overwrite();
    logic [31:0] d;
    key(8'h10);
    key(8'h22);
    rd(A_RXC, d); chk("R5 ready stays", d, 32'h1);
    rd(A_RXD, d); chk("R5 newest byte", d, 32'h22);
  endtask

  task automatic t_rx_collision();
    logic [31:0] d;
    key(8'h33);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_RXD;
    kbd_valid = 1'b1; kbd_byte = 8'h55;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; kbd_valid = 1'b0;
    chk("R4 collision old byte", d, 32'h33);
    rd(A_RXC, d); chk("R4 collision ready kept", d, 32'h1);
    rd(A_RXD, d); chk("R4 collision new byte", d, 32'h55);
    rd(A_RXC, d); chk("R4 cleared after", d, 32'h0);
  endtask

  task automatic t_rx_ctl_irq();
    logic [31:0] d;
    wr(A_RXC, 32'hFFFF_FFFF);
    rd(A_RXC, d); chk("R2 ready not writable, ie set", d, 32'h2);
    chk("R9 no irq without ready", 32'(irq_rx), 0);
    key(8'h07);
    chk("R9 rx irq raised", 32'(irq_rx), 1);
    rd(A_RXD, d);
    chk("R9 rx irq dropped", 32'(irq_rx), 0);
    key(8'h08);
    wr(A_RXC, 32'h0);
    chk("R9 rx irq off with ie", 32'(irq_rx), 0);
    rd(A_RXC, d); chk("R2 ie cleared", d, 32'h1);
    rd(A_RXD, d);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    wr(A_TXD, 32'h1234_56AB);
    chk("R6 start pulse", 32'(disp_start), 1);
    chk("R6 display byte", 32'(disp_byte), 32'hAB);
    rd(A_TXC, d); chk("R6 ready cleared", d, 32'h0);
    chk("R6 single pulse", 32'(disp_start), 0);
    wr(A_TXD, 32'h0000_00CD);
    chk("R7 no pulse when busy", 32'(disp_start), 0);
    chk("R7 byte held", 32'(disp_byte), 32'hAB);
    done_pulse();
    rd(A_TXC, d); chk("R8 done sets ready", d, 32'h1);
  endtask

  task automatic t_tx_irq();
    logic [31:0] d;
    wr(A_TXC, 32'h2);
    rd(A_TXC, d); chk("R2 tx ctl", d, 32'h3);
    chk("R9 tx irq", 32'(irq_tx), 1);
    wr(A_TXD, 32'h5A);
    chk("R9 tx irq drops on send", 32'(irq_tx), 0);
    done_pulse();
    chk("R9 tx irq back", 32'(irq_tx), 1);
    wr(A_TXC, 32'h0);
    chk("R9 tx irq disabled", 32'(irq_tx), 0);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(B + 32'h10, 32'hFFFF_FFFF);
    wr(32'hFFFE_0008, 32'h2);
    wr(B + 32'h1, 32'h2);
    rd(B + 32'h10, d); chk("R1 above window", d, 32'h0);
    rd(32'hFFFE_0000, d); chk("R1 other page", d, 32'h0);
    rd(B + 32'h9, d); chk("R1 unaligned", d, 32'h0);
    rd(A_RXC, d); chk("R1 rx ctl untouched", d, 32'h0);
    rd(A_TXC, d); chk("R1 tx ctl untouched", d, 32'h1);
    rd(A_TXD, d); chk("R1 tx data reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rx_basic();
    t_rx_overwrite();
    t_rx_collision();
    t_rx_ctl_irq();
    t_tx();
    t_tx_irq();
    t_window();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule